// File: doc/BRIEF.md
# I2C Quasi-Bidirectional Port Expander

This block is an I2C target that drives an eight-pin port. The port has no direction register. Each pin is either released high through a weak pull-up, which lets it be used as an input, or pulled low. SCL and SDA are oversampled in the system clock domain. The block finds START and STOP conditions, compares the received address with a fixed upper field followed by three strap inputs, and then runs one of two transfer types. A write stores one data byte into the port latch. A read returns the live pin levels.

For each pin the block outputs three enables for the pad: a weak pull-up, a strong pull-up and a pull-down. The strong pull-up gives a fast rising edge after a 1 is written, and it is cut at the next SCL falling edge. The block also outputs single-cycle read and write strobes, which nearby interrupt logic uses to re-arm its change detector. SDA is driven as an open-drain enable: when `sda_oe` is 1 the line is pulled low.

Top module: `qbx_expander`

## Requirements
- R1: After reset every latch bit is 1, so `weak_pu_o` is all ones, `pull_dn_o` and `strong_pu_o` are all zeros, and `sda_oe` is 0.
- R2: The 7-bit target address is binary 0100 followed by `strap_i[2:0]`, shifted MSB first, with the read/write bit (1 = read) as the eighth bit. Only a matching address is acknowledged, by holding `sda_oe` high across the ninth SCL clock.
- R3: The all-zero general-call address is never acknowledged.
- R4: On a write, the first data byte after the address goes MSB first into latch bits 7..0. Pin n then has `pull_dn_o[n]` equal to the inverse of its latch bit and `weak_pu_o[n]` equal to the latch bit. The new levels appear at the SCL rising edge of that byte's acknowledge clock.
- R5: A pin whose bit is written as 1 has `strong_pu_o` set from that commit until the next SCL falling edge. `strong_pu_o` and `pull_dn_o` are never both high on a pin.
- R6: The port does not change before the acknowledge clock of a complete data byte. A byte cut short by STOP leaves the port unchanged.
- R7: Further data bytes in the same write transfer are acknowledged but do not change the port.
- R8: On a read, the byte sent is the pin state P7..P0, P7 first. The pins are sampled at the SCL falling edge that ends the previous acknowledge.
- R9: After a read byte, a master ACK starts another byte with freshly sampled pins. A master NACK releases SDA, and the block stays silent until the next START or STOP.
- R10: A START or STOP seen at any point abandons the current byte. A repeated START is accepted as a new address phase.
- R11: `sda_oe` changes only while SCL is low.
- R12: `read_strobe` pulses for one cycle in the acknowledge clock of every read byte. `write_strobe` pulses for one cycle only for the first data byte of a write transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level (wired bus) |
| sda_oe | output | 1 | 1 pulls SDA low |
| strap_i | input | 3 | Low address bits from board straps |
| pin_i | input | 8 | Sensed levels of port pins P7..P0 |
| weak_pu_o | output | 8 | Per-pin weak pull-up enable |
| strong_pu_o | output | 8 | Per-pin strong pull-up enable |
| pull_dn_o | output | 8 | Per-pin pull-down enable |
| write_strobe | output | 1 | One-cycle pulse when a write byte commits |
| read_strobe | output | 1 | One-cycle pulse in each read acknowledge |

## Verification
The bench sweeps all 128 address values with one strap setting and the matching address for every strap value. This catches a design that decodes the wrong bits or acknowledges the general call. It checks the port one step before the acknowledge clock and again inside it. A design that commits too early, or drops the strong pull-up late, changes a pin at the wrong point. Multi-byte writes, transfers cut short by STOP or repeated START, and ACK/NACK read chains with pins changing between bytes target a design that writes the extra bytes, keeps stale pin samples, or holds SDA after a NACK.

// File: rtl/qbx_pkg.sv
package qbx_pkg;

   localparam int BYTE_W = 8;
   localparam int CNT_W  = $clog2(BYTE_W + 1);

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_WR_DATA,
      ST_WR_ACK,
      ST_RD_DATA,
      ST_RD_ACK,
      ST_HOLD
   } bus_state_e;

   typedef struct packed {
      logic rise;
      logic fall;
      logic start;
      logic stop;
      logic sda;
   } bus_evt_t;

endpackage

// File: rtl/qbx_sync.sv
module qbx_sync #(
   parameter int W       = 1,
   parameter int STAGES  = 2,
   parameter bit RST_BIT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {(STAGES*W){RST_BIT}};
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/qbx_line_monitor.sv
module qbx_line_monitor
   import qbx_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     scl_i,
   input  logic     sda_i,
   output bus_evt_t evt_o
);

   logic [1:0] line_s;
   logic       scl_q;
   logic       sda_q;

   qbx_sync #(
      .W       (2),
      .STAGES  (SYNC_STAGES),
      .RST_BIT (1'b1)
   ) u_line_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({scl_i, sda_i}),
      .q_o   (line_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= line_s[1];
         sda_q <= line_s[0];
      end
   end

   always_comb begin
      evt_o.rise  = line_s[1] & ~scl_q;
      evt_o.fall  = ~line_s[1] & scl_q;
      evt_o.start = line_s[1] & scl_q & sda_q & ~line_s[0];
      evt_o.stop  = line_s[1] & scl_q & ~sda_q & line_s[0];
      evt_o.sda   = line_s[0];
   end

endmodule

// File: rtl/qbx_bus_fsm.sv
module qbx_bus_fsm
   import qbx_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  bus_evt_t          evt_i,
   input  logic [6:0]        dev_addr_i,
   input  logic [BYTE_W-1:0] pin_s_i,
   output logic              sda_oe_o,
   output logic              wr_strobe_o,
   output logic [BYTE_W-1:0] wr_data_o,
   output logic              rd_strobe_o
);

   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

   bus_state_e        state_q;
   logic [CNT_W-1:0]  bit_cnt_q;
   logic [BYTE_W-1:0] rx_q;
   logic [BYTE_W-2:0] tx_q;
   logic              rw_q;
   logic              wr_done_q;
   logic              more_q;
   logic              addr_hit;

   // general call never matches, even with a zero base and zero straps
   assign addr_hit = (rx_q[BYTE_W-1:1] == dev_addr_i) && (dev_addr_i != 7'd0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         bit_cnt_q   <= '0;
         rx_q        <= '0;
         tx_q        <= '0;
         rw_q        <= 1'b0;
         wr_done_q   <= 1'b0;
         more_q      <= 1'b0;
         sda_oe_o    <= 1'b0;
         wr_strobe_o <= 1'b0;
         wr_data_o   <= '1;
         rd_strobe_o <= 1'b0;
      end else begin
         wr_strobe_o <= 1'b0;
         rd_strobe_o <= 1'b0;
         if (evt_i.start) begin
            state_q   <= ST_ADDR;
            bit_cnt_q <= '0;
            wr_done_q <= 1'b0;
            sda_oe_o  <= 1'b0;
         end else if (evt_i.stop) begin
            state_q  <= ST_IDLE;
            sda_oe_o <= 1'b0;
         end else begin
            unique case (state_q)
               ST_ADDR, ST_WR_DATA: begin
                  if (evt_i.rise) begin
                     rx_q      <= {rx_q[BYTE_W-2:0], evt_i.sda};
                     bit_cnt_q <= bit_cnt_q + 1'b1;
                  end else if (evt_i.fall && bit_cnt_q == CNT_FULL) begin
                     bit_cnt_q <= '0;
                     if (state_q == ST_WR_DATA) begin
                        state_q  <= ST_WR_ACK;
                        sda_oe_o <= 1'b1;
                     end else if (addr_hit) begin
                        state_q  <= ST_ADDR_ACK;
                        sda_oe_o <= 1'b1;
                        rw_q     <= rx_q[0];
                     end else begin
                        state_q <= ST_HOLD;
                     end
                  end
               end
               ST_ADDR_ACK: begin
                  if (evt_i.fall) begin
                     if (rw_q) begin
                        state_q  <= ST_RD_DATA;
                        tx_q     <= pin_s_i[BYTE_W-2:0];
                        sda_oe_o <= ~pin_s_i[BYTE_W-1];
                     end else begin
                        state_q  <= ST_WR_DATA;
                        sda_oe_o <= 1'b0;
                     end
                  end
               end
               ST_WR_ACK: begin
                  if (evt_i.rise && !wr_done_q) begin
                     wr_strobe_o <= 1'b1;
                     wr_data_o   <= rx_q;
                  end else if (evt_i.fall) begin
                     wr_done_q <= 1'b1;
                     sda_oe_o  <= 1'b0;
                     state_q   <= ST_WR_DATA;
                  end
               end
               ST_RD_DATA: begin
                  if (evt_i.fall) begin
                     if (bit_cnt_q == CNT_LAST) begin
                        bit_cnt_q <= '0;
                        sda_oe_o  <= 1'b0;
                        state_q   <= ST_RD_ACK;
                     end else begin
                        bit_cnt_q <= bit_cnt_q + 1'b1;
                        sda_oe_o  <= ~tx_q[BYTE_W-2];
                        tx_q      <= {tx_q[BYTE_W-3:0], 1'b0};
                     end
                  end
               end
               ST_RD_ACK: begin
                  if (evt_i.rise) begin
                     rd_strobe_o <= 1'b1;
                     more_q      <= ~evt_i.sda;
                  end else if (evt_i.fall) begin
                     if (more_q) begin
                        state_q  <= ST_RD_DATA;
                        tx_q     <= pin_s_i[BYTE_W-2:0];
                        sda_oe_o <= ~pin_s_i[BYTE_W-1];
                     end else begin
                        state_q <= ST_HOLD;
                     end
                  end
               end
               default: begin
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/qbx_port_cell.sv
module qbx_port_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   input  logic data_i,
   input  logic scl_fall_i,
   output logic weak_pu_o,
   output logic strong_pu_o,
   output logic pull_dn_o
);

   logic level_q;
   logic boost_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= 1'b1;
         boost_q <= 1'b0;
      end else if (load_i) begin
         level_q <= data_i;
         boost_q <= data_i;
      end else if (scl_fall_i) begin
         boost_q <= 1'b0;
      end
   end

   assign weak_pu_o   = level_q;
   assign strong_pu_o = boost_q;
   assign pull_dn_o   = ~level_q;

endmodule

// File: rtl/qbx_expander.sv
module qbx_expander
   import qbx_pkg::*;
#(
   parameter int         PORT_W      = 8,
   parameter int         STRAP_W     = 3,
   parameter logic [6:0] BASE_ADDR   = 7'h20,
   parameter int         SYNC_STAGES = 2,
   parameter bit         PIN_SYNC    = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_i,
   input  logic               sda_i,
   output logic               sda_oe,
   input  logic [STRAP_W-1:0] strap_i,
   input  logic [PORT_W-1:0]  pin_i,
   output logic [PORT_W-1:0]  weak_pu_o,
   output logic [PORT_W-1:0]  strong_pu_o,
   output logic [PORT_W-1:0]  pull_dn_o,
   output logic               write_strobe,
   output logic               read_strobe
);

   if (PORT_W != BYTE_W) begin : g_bad_port_w
      $error("qbx_expander: PORT_W must equal the byte width");
   end
   if (STRAP_W < 1 || STRAP_W > 6) begin : g_bad_strap_w
      $error("qbx_expander: STRAP_W out of range");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("qbx_expander: SYNC_STAGES must be at least 2");
   end
   if (BASE_ADDR[STRAP_W-1:0] != '0) begin : g_bad_base
      $error("qbx_expander: BASE_ADDR low bits must be zero");
   end

   bus_evt_t          evt;
   logic [6:0]        dev_addr;
   logic [PORT_W-1:0] pin_s;
   logic [PORT_W-1:0] wr_data;

   assign dev_addr = {BASE_ADDR[6:STRAP_W], strap_i};

   if (PIN_SYNC) begin : g_pin_sync
      qbx_sync #(
         .W       (PORT_W),
         .STAGES  (SYNC_STAGES),
         .RST_BIT (1'b1)
      ) u_pin_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d_i   (pin_i),
         .q_o   (pin_s)
      );
   end else begin : g_pin_direct
      assign pin_s = pin_i;
   end

   qbx_line_monitor #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_monitor (
      .clk   (clk),
      .rst_n (rst_n),
      .scl_i (scl_i),
      .sda_i (sda_i),
      .evt_o (evt)
   );

   qbx_bus_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .evt_i       (evt),
      .dev_addr_i  (dev_addr),
      .pin_s_i     (pin_s),
      .sda_oe_o    (sda_oe),
      .wr_strobe_o (write_strobe),
      .wr_data_o   (wr_data),
      .rd_strobe_o (read_strobe)
   );

   for (genvar i = 0; i < PORT_W; i++) begin : g_cell
      qbx_port_cell u_cell (
         .clk         (clk),
         .rst_n       (rst_n),
         .load_i      (write_strobe),
         .data_i      (wr_data[i]),
         .scl_fall_i  (evt.fall),
         .weak_pu_o   (weak_pu_o[i]),
         .strong_pu_o (strong_pu_o[i]),
         .pull_dn_o   (pull_dn_o[i])
      );
   end

endmodule

// File: rtl/qbx_expander_chk.sv
module qbx_expander_chk #(
   parameter int PORT_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_i,
   input logic              sda_oe,
   input logic [PORT_W-1:0] strong_pu_o,
   input logic [PORT_W-1:0] pull_dn_o,
   input logic              write_strobe,
   input logic              read_strobe
);

   p_oe_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_i)
      else $error("sda_oe changed while SCL high");

   p_port_on_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pull_dn_o) |-> $past(write_strobe))
      else $error("port changed without a write commit");

   p_boost_on_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (|(strong_pu_o & ~$past(strong_pu_o))) |-> $past(write_strobe))
      else $error("strong pull-up rose without a write commit");

   p_boost_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (strong_pu_o & pull_dn_o) == '0)
      else $error("strong pull-up and pull-down together");

   p_wr_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      write_strobe |=> !write_strobe)
      else $error("write strobe longer than one cycle");

   p_rd_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      read_strobe |=> !read_strobe)
      else $error("read strobe longer than one cycle");

   p_strobe_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !(write_strobe && read_strobe))
      else $error("read and write strobes together");

endmodule

bind qbx_expander qbx_expander_chk #(.PORT_W(PORT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .scl_i        (scl_i),
   .sda_oe       (sda_oe),
   .strong_pu_o  (strong_pu_o),
   .pull_dn_o    (pull_dn_o),
   .write_strobe (write_strobe),
   .read_strobe  (read_strobe)
);

// File: tb/qbx_expander_tb_top.sv
`timescale 1ns/1ps
module qbx_expander_tb_top;

   localparam int H = 8;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       m_scl = 1'b1;
   logic       m_sda = 1'b1;
   logic       sda_bus;
   logic [2:0] strap;
   logic [7:0] pins;
   logic       sda_oe;
   logic [7:0] weak_pu, strong_pu, pull_dn;
   logic       write_strobe, read_strobe;

   int n_chk = 0;
   int n_err = 0;
   int wr_pulses = 0;
   int rd_pulses = 0;
   logic [7:0] exp_port = 8'hFF;

   always #2.5 clk = ~clk;

   assign sda_bus = m_sda & ~sda_oe;

   qbx_expander dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .scl_i        (m_scl),
      .sda_i        (sda_bus),
      .sda_oe       (sda_oe),
      .strap_i      (strap),
      .pin_i        (pins),
      .weak_pu_o    (weak_pu),
      .strong_pu_o  (strong_pu),
      .pull_dn_o    (pull_dn),
      .write_strobe (write_strobe),
      .read_strobe  (read_strobe)
   );

   always @(posedge clk) begin
      if (write_strobe) wr_pulses++;
      if (read_strobe)  rd_pulses++;
   end

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wait_h();
      repeat (H) @(negedge clk);
   endtask

   task automatic bit_cycle(input logic b, output logic seen);
      wait_h();
      m_sda = b;
      wait_h();
      m_scl = 1'b1;
      wait_h();
      seen = sda_bus;
      wait_h();
      m_scl = 1'b0;
   endtask

   task automatic bus_start();
      wait_h();
      m_sda = 1'b1;
      wait_h();
      m_scl = 1'b1;
      wait_h();
      m_sda = 1'b0;
      wait_h();
      m_scl = 1'b0;
   endtask

   task automatic bus_stop();
      wait_h();
      m_sda = 1'b0;
      wait_h();
      m_scl = 1'b1;
      wait_h();
      m_sda = 1'b1;
      wait_h();
   endtask

   task automatic send_byte(input logic [7:0] v, output logic ack);
      logic s;
      for (int i = 7; i >= 0; i--) bit_cycle(v[i], s);
      bit_cycle(1'b1, s);
      ack = ~s;
   endtask

   task automatic read_byte(input logic mack, input logic [7:0] nxt, output logic [7:0] v);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         bit_cycle(1'b1, s);
         v[i] = s;
      end
      pins = nxt;
      bit_cycle(~mack, s);
   endtask

   // full write data byte with checks before and inside the acknowledge clock
   task automatic write_data(input logic [7:0] v, input logic first);
      logic s;
      for (int i = 7; i >= 0; i--) bit_cycle(v[i], s);
      chk("R6 port before ack", pull_dn, ~exp_port);
      wait_h();
      m_sda = 1'b1;
      wait_h();
      m_scl = 1'b1;
      wait_h();
      chk("R4 data ack", {7'd0, ~sda_bus}, 8'd1);
      if (first) begin
         exp_port = v;
         chk("R5 strong in ack", strong_pu, v);
      end else begin
         chk("R7 no boost on extra byte", strong_pu, 8'h00);
      end
      chk("R4 pull_dn in ack", pull_dn, ~exp_port);
      chk("R4 weak in ack", weak_pu, exp_port);
      wait_h();
      m_scl = 1'b0;
      wait_h();
      chk("R5 strong cut at fall", strong_pu, 8'h00);
   endtask

   initial begin
      logic       ack, s;
      logic [7:0] v, w;
      int         p0;
      rst_n = 1'b0;
      strap = 3'd5;
      pins  = 8'h3C;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      chk("R1 weak", weak_pu, 8'hFF);
      chk("R1 pull_dn", pull_dn, 8'h00);
      chk("R1 strong", strong_pu, 8'h00);
      chk("R1 sda_oe", {7'd0, sda_oe}, 8'h00);

      // R2 / R3: every 7-bit address, read direction
      for (int a = 0; a < 128; a++) begin
         bus_start();
         send_byte({a[6:0], 1'b1}, ack);
         if (a == 0) chk("R3 general call", {7'd0, ack}, 8'h00);
         else chk("R2 address sweep", {7'd0, ack}, {7'd0, (a[6:0] == {4'b0100, strap})});
         if (ack) begin
            read_byte(1'b0, pins, v);
            chk("R8 read value", v, 8'h3C);
         end
         bus_stop();
      end

      // R2: each strap value
      for (int k = 0; k < 8; k++) begin
         strap = 3'(k);
         bus_start();
         send_byte({4'b0100, 3'(k ^ 1), 1'b1}, ack);
         chk("R2 wrong strap", {7'd0, ack}, 8'h00);
         bus_start();
         send_byte({4'b0100, 3'(k), 1'b1}, ack);
         chk("R2 strap match", {7'd0, ack}, 8'h01);
         pins = 8'(k * 29 + 3);
         if (ack) begin
            read_byte(1'b0, pins, v);
            chk("R8 read after restart", v, 8'(k * 29 + 3));
         end
         bus_stop();
      end
      strap = 3'd2;

      // R4 / R5 / R12: write patterns
      for (int k = 0; k < 16; k++) begin
         v = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'((k * 37) ^ 8'hA5);
         p0 = wr_pulses;
         bus_start();
         send_byte({7'h22, 1'b0}, ack);
         chk("R2 write address", {7'd0, ack}, 8'h01);
         write_data(v, 1'b1);
         bus_stop();
         chk("R12 one write strobe", 8'(wr_pulses - p0), 8'd1);
         chk("R4 port after stop", weak_pu, v);
      end

      // R7: extra bytes ignored
      p0 = wr_pulses;
      bus_start();
      send_byte({7'h22, 1'b0}, ack);
      write_data(8'h81, 1'b1);
      write_data(8'h7E, 1'b0);
      write_data(8'h00, 1'b0);
      bus_stop();
      chk("R7 port keeps first byte", pull_dn, 8'h7E);
      chk("R12 write strobe count", 8'(wr_pulses - p0), 8'd1);

      // R6 / R10: partial byte cut by STOP
      bus_start();
      send_byte({7'h22, 1'b0}, ack);
      for (int i = 0; i < 5; i++) bit_cycle(1'b0, s);
      bus_stop();
      chk("R6 partial byte", pull_dn, 8'h7E);

      // R10: repeated START mid address, then a valid read
      pins = 8'h96;
      bus_start();
      for (int i = 0; i < 4; i++) bit_cycle(1'b0, s);
      bus_start();
      send_byte({7'h22, 1'b1}, ack);
      chk("R10 restart accepted", {7'd0, ack}, 8'h01);
      read_byte(1'b0, pins, v);
      chk("R8 read after repeated start", v, 8'h96);
      bus_stop();

      // R9 / R12: chained read with pins changing between bytes
      pins = 8'hC3;
      p0 = rd_pulses;
      bus_start();
      send_byte({7'h22, 1'b1}, ack);
      read_byte(1'b1, 8'h5A, v);
      chk("R8 first byte", v, 8'hC3);
      read_byte(1'b1, 8'h01, w);
      chk("R9 resampled second byte", w, 8'h5A);
      read_byte(1'b0, 8'hFF, w);
      chk("R9 third byte", w, 8'h01);
      bit_cycle(1'b1, s);
      chk("R9 released after NACK", {7'd0, s}, 8'h01);
      chk("R9 sda_oe idle", {7'd0, sda_oe}, 8'h00);
      bus_stop();
      chk("R12 read strobe count", 8'(rd_pulses - p0), 8'd3);
      chk("R7 port unchanged by reads", weak_pu, 8'h81);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule